// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

This block is the integer execution unit of a small register-based virtual machine of the kind used to run packet-filtering programs. Each operation arrives as an 8-bit opcode together with the current destination register value, the source register value and the 32-bit immediate. The unit returns the value to write back to the destination register and a write-enable. The register file, instruction fetch, memory access and branching belong to the surrounding core.

Two arithmetic classes share one datapath. The wide class works on all 64 bits. The narrow class works on the low 32 bits and clears the upper half of the result. Unsigned divide and modulo run on a restoring radix-2 divider for a fixed number of cycles. All other operations complete in the cycle they are issued. The unit also performs the endian-conversion operation, whose width comes from the immediate, and it flags opcodes it does not implement.

Top module: `vm_int_alu`

## Requirements
- R1: Opcode bits 2:0 give the class: 4 is the narrow class and 7 is the wide class. Bit 3 picks the second operand: 1 selects `srcVal` and 0 selects the immediate. Bits 7:4 give the operation: 0 add, 1 sub, 2 mul, 3 div, 4 or, 5 and, 6 shift left, 7 logical shift right, 8 negate, 9 mod, A xor, B move, C arithmetic shift right, D byte swap. Every operation other than divide and modulo raises `done` in the cycle that `start` is accepted, with the result and `writeEn` valid in that same cycle.
- R2: In the narrow class the operation uses bits 31:0 of the operands and result bits 63:32 are zero. Add, sub and mul wrap silently in both classes.
- R3: The immediate is zero-extended in the narrow class. It is sign-extended from bit 31 in the wide class, and this also applies to divide and modulo.
- R4: The shift amount is the second operand masked to 5 bits in the narrow class and to 6 bits in the wide class. Arithmetic shift right fills with bit 31 (narrow) or bit 63 (wide).
- R5: Negate returns the two's complement of `dstVal` and ignores the second operand. Move returns the second operand.
- R6: An accepted divide or modulo holds `busy` high for exactly 64 cycles. In the following cycle `done` pulses once with the result, and `writeEn` is high. The division is unsigned.
- R7: Division by zero yields 0. Modulo by zero yields `dstVal` unchanged in the wide class, and its low 32 bits zero-extended in the narrow class.
- R8: Byte swap (opcode 0xD4 or 0xDC, narrow class only) ignores `srcVal`. The immediate gives the width: 16, 32 or 64. Bit 3 = 0 returns the low bytes of that width zero-extended. Bit 3 = 1 returns those bytes in reversed order, zero-extended. Bits 63:32 are not cleared for width 64.
- R9: An illegal operation raises `illegal` and `done` in the cycle it is accepted, with `writeEn` low. Illegal operations are a class other than 4 or 7, operation code E or F, byte swap in the wide class, or a byte-swap width other than 16, 32 or 64.
- R10: `start` is ignored while `busy` is high and in the cycle the divider's `done` is high. It produces no extra `done` and does not change the pending result.
- R11: While `rstN` is low, `busy`, `done`, `writeEn` and `illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the operation on the other inputs this cycle |
| opcode | input | 8 | Operation encoding |
| dstVal | input | 64 | Destination register value |
| srcVal | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| result | output | 64 | Value to write back |
| writeEn | output | 1 | Write `result` to the destination register |
| done | output | 1 | Operation complete this cycle |
| busy | output | 1 | Divider running; new issues are ignored |
| illegal | output | 1 | Issued opcode or byte-swap width is not implemented |

## Verification
Single-cycle operations and illegal opcodes are due in the cycle `start` is accepted. The bench drives inputs on the falling edge and compares results one nanosecond later, still within that cycle. A divide or modulo is due 65 cycles after acceptance: 64 busy cycles, then the cycle with `done`. The bench counts the busy cycles it sees and takes the result only when `done` appears. The scoreboard queue fails any `done` that arrives with no item pending, which catches both early results and issues that should have been ignored during a divide.

// File: rtl/vmalu_pkg.sv
package vmalu_pkg;

  localparam logic [2:0] CLS_NARROW = 3'd4;
  localparam logic [2:0] CLS_WIDE   = 3'd7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_SAR  = 4'hC,
    OP_SWAP = 4'hD
  } aluOp_e;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swapW_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e op;
    logic   narrow;
    logic   useReg;
    logic   toBig;
    swapW_e swapW;
    logic   divLoad;
    logic   divStep;
  } ctrlStrobe_t;

endpackage

// File: rtl/vmalu_ctrl.sv
module vmalu_ctrl
  import vmalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [IMM_W-1:0]  imm,
  output ctrlStrobe_t       strb,
  output logic              busy,
  output logic              accepted,
  output logic              illegal,
  output logic              singleDone,
  output logic              divDone
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [2:0]       opClass;
  logic [3:0]       opCode;
  logic             classOk, codeOk, swapWidthOk, isSwap, isDivOp, legal, loadDiv;
  logic             busyR, divDoneR;
  logic [CNT_W-1:0] cntR;

  always_comb begin
    opClass     = opcode[2:0];
    opCode      = opcode[7:4];
    classOk     = (opClass == CLS_NARROW) || (opClass == CLS_WIDE);
    isSwap      = (opCode == 4'hD);
    swapWidthOk = (imm == IMM_W'(16)) || (imm == IMM_W'(32)) || (imm == IMM_W'(64));
    codeOk      = (opCode <= 4'hC) || (isSwap && (opClass == CLS_NARROW) && swapWidthOk);
    legal       = classOk && codeOk;
    isDivOp     = (opCode == 4'h3) || (opCode == 4'h9);
    accepted    = start && !busyR && !divDoneR;
    illegal     = accepted && !legal;
    loadDiv     = accepted && legal && isDivOp;
    singleDone  = accepted && !loadDiv;
  end

  always_comb begin
    strb.op      = aluOp_e'(opCode);
    strb.narrow  = (opClass == CLS_NARROW);
    strb.useReg  = opcode[3];
    strb.toBig   = opcode[3];
    if (imm == IMM_W'(16))      strb.swapW = SW_16;
    else if (imm == IMM_W'(32)) strb.swapW = SW_32;
    else                        strb.swapW = SW_64;
    strb.divLoad = loadDiv;
    strb.divStep = busyR;
  end

  // divider sequencing: DATA_W step cycles, then one done cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      divDoneR <= 1'b0;
      cntR     <= '0;
    end else begin
      divDoneR <= 1'b0;
      if (loadDiv) begin
        busyR <= 1'b1;
        cntR  <= CNT_W'(DATA_W);
      end else if (busyR) begin
        cntR <= cntR - CNT_W'(1);
        if (cntR == CNT_W'(1)) begin
          busyR    <= 1'b0;
          divDoneR <= 1'b1;
        end
      end
    end
  end

  assign busy    = busyR;
  assign divDone = divDoneR;

endmodule

// File: rtl/vmalu_dp.sv
module vmalu_dp
  import vmalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] aluRes,
  output logic [DATA_W-1:0] divRes
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int SHN_W  = $clog2(HALF_W);
  localparam int EXT_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt, opB, wideRes, swapRes;
  logic [HALF_W-1:0] aLo, bLo, narrowRes;
  logic [SH_W-1:0]   shW;
  logic [SHN_W-1:0]  shN;
  logic [15:0]       be16;
  logic [31:0]       be32;
  logic [DATA_W-1:0] beAll;

  // operand selection and immediate extension
  always_comb begin
    immExt = strb.narrow ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
    opB    = strb.useReg ? srcVal : immExt;
    aLo    = dstVal[HALF_W-1:0];
    bLo    = opB[HALF_W-1:0];
    shW    = opB[SH_W-1:0];
    shN    = opB[SHN_W-1:0];
  end

  always_comb begin
    wideRes = '0;
    case (strb.op)
      OP_ADD:  wideRes = dstVal + opB;
      OP_SUB:  wideRes = dstVal - opB;
      OP_MUL:  wideRes = dstVal * opB;
      OP_OR:   wideRes = dstVal | opB;
      OP_AND:  wideRes = dstVal & opB;
      OP_XOR:  wideRes = dstVal ^ opB;
      OP_SHL:  wideRes = dstVal << shW;
      OP_SHR:  wideRes = dstVal >> shW;
      OP_SAR:  wideRes = $signed(dstVal) >>> shW;
      OP_NEG:  wideRes = -dstVal;
      OP_MOV:  wideRes = opB;
      default: wideRes = '0;
    endcase
  end

  always_comb begin
    narrowRes = '0;
    case (strb.op)
      OP_ADD:  narrowRes = aLo + bLo;
      OP_SUB:  narrowRes = aLo - bLo;
      OP_MUL:  narrowRes = aLo * bLo;
      OP_OR:   narrowRes = aLo | bLo;
      OP_AND:  narrowRes = aLo & bLo;
      OP_XOR:  narrowRes = aLo ^ bLo;
      OP_SHL:  narrowRes = aLo << shN;
      OP_SHR:  narrowRes = aLo >> shN;
      OP_SAR:  narrowRes = $signed(aLo) >>> shN;
      OP_NEG:  narrowRes = -aLo;
      OP_MOV:  narrowRes = bLo;
      default: narrowRes = '0;
    endcase
  end

  // endian conversion, host order taken as little-endian
  always_comb begin
    for (int i = 0; i < 2; i++) be16[8*i +: 8] = dstVal[8*(1-i) +: 8];
    for (int i = 0; i < 4; i++) be32[8*i +: 8] = dstVal[8*(3-i) +: 8];
    for (int i = 0; i < DATA_W/8; i++) beAll[8*i +: 8] = dstVal[8*(DATA_W/8-1-i) +: 8];
    case (strb.swapW)
      SW_16:   swapRes = strb.toBig ? {{(DATA_W-16){1'b0}}, be16}
                                    : {{(DATA_W-16){1'b0}}, dstVal[15:0]};
      SW_32:   swapRes = strb.toBig ? {{(DATA_W-32){1'b0}}, be32}
                                    : {{(DATA_W-32){1'b0}}, dstVal[31:0]};
      default: swapRes = strb.toBig ? beAll : dstVal;
    endcase
  end

  always_comb begin
    if (strb.op == OP_SWAP)  aluRes = swapRes;
    else if (strb.narrow)    aluRes = {{HALF_W{1'b0}}, narrowRes};
    else                     aluRes = wideRes;
  end

  // restoring radix-2 divider
  logic [DATA_W-1:0] remR, quoR, dsrR, dvdR;
  logic              modR;
  logic [DATA_W:0]   trial;
  logic              dsrZero;

  assign trial   = {remR, quoR[DATA_W-1]} - {1'b0, dsrR};
  assign dsrZero = (dsrR == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      dsrR <= '0;
      dvdR <= '0;
      modR <= 1'b0;
    end else if (strb.divLoad) begin
      remR <= '0;
      quoR <= strb.narrow ? {{HALF_W{1'b0}}, aLo} : dstVal;
      dvdR <= strb.narrow ? {{HALF_W{1'b0}}, aLo} : dstVal;
      dsrR <= strb.narrow ? {{HALF_W{1'b0}}, bLo} : opB;
      modR <= (strb.op == OP_MOD);
    end else if (strb.divStep) begin
      if (!trial[DATA_W]) begin
        remR <= trial[DATA_W-1:0];
        quoR <= {quoR[DATA_W-2:0], 1'b1};
      end else begin
        remR <= {remR[DATA_W-2:0], quoR[DATA_W-1]};
        quoR <= {quoR[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    if (modR) divRes = dsrZero ? dvdR : remR;
    else      divRes = dsrZero ? '0 : quoR;
  end

endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
  import vmalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              done,
  output logic              busy,
  output logic              illegal
);

  ctrlStrobe_t       strb;
  logic              accepted, singleDone, divDone;
  logic [DATA_W-1:0] aluRes, divRes;

  vmalu_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .opcode     (opcode),
    .imm        (imm),
    .strb       (strb),
    .busy       (busy),
    .accepted   (accepted),
    .illegal    (illegal),
    .singleDone (singleDone),
    .divDone    (divDone)
  );

  vmalu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dstVal (dstVal),
    .srcVal (srcVal),
    .imm    (imm),
    .aluRes (aluRes),
    .divRes (divRes)
  );

  assign result  = divDone ? divRes : aluRes;
  assign done    = divDone || singleDone;
  assign writeEn = done && !illegal;

endmodule

// File: rtl/vmalu_chk.sv
module vmalu_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [2:0]          opCls,
  input logic [3:0]          opCode,
  input logic                accepted,
  input logic                busy,
  input logic                done,
  input logic                writeEn,
  input logic                illegal,
  input logic [DATA_W/2-1:0] resultHigh
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CNT_W'(1);
    else           busyCnt <= '0;
  end

  assert_no_done_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CNT_W'(DATA_W)));

  assert_div_done_after_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && writeEn && busyCnt == CNT_W'(DATA_W)));

  assert_busy_needs_issue_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !writeEn));

  assert_narrow_upper_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !illegal && opCls == 3'd4 && opCode != 4'hD &&
     opCode != 4'h3 && opCode != 4'h9) |-> (resultHigh == '0));

  // R11: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R11: assert (!busy && !done && !writeEn && !illegal);
  end

endmodule

bind vm_int_alu vmalu_chk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .opCls      (opcode[2:0]),
  .opCode     (opcode[7:4]),
  .accepted   (accepted),
  .busy       (busy),
  .done       (done),
  .writeEn    (writeEn),
  .illegal    (illegal),
  .resultHigh (result[DATA_W-1:DATA_W/2])
);

// File: tb/tb_vm_int_alu.sv
`timescale 1ns/1ps
module tb_vm_int_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dstVal = '0;
  logic [63:0] srcVal = '0;
  logic [31:0] imm = '0;
  logic [63:0] result;
  logic        writeEn, done, busy, illegal;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [63:0] res;
    bit          ill;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  vm_int_alu dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dstVal(dstVal), .srcVal(srcVal), .imm(imm),
    .result(result), .writeEn(writeEn), .done(done), .busy(busy), .illegal(illegal)
  );

  // monitor: compare every completion with the head of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && done) begin
        checks++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected done: result=%h we=%0d ill=%0d, expected no completion",
                   result, writeEn, illegal);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (illegal !== e.ill || writeEn !== !e.ill || (!e.ill && result !== e.res)) begin
            fails++;
            $display("FAIL %s: result=%h we=%0d ill=%0d, expected result=%h we=%0d ill=%0d",
                     e.tag, result, writeEn, illegal, e.res, !e.ill, e.ill);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                      input logic [31:0] im, input logic [63:0] er, input bit eill,
                      input string tag);
    bit isDiv;
    int cnt;
    exp_t e;
    e.res = er; e.ill = eill; e.tag = tag;
    sbq.push_back(e);
    isDiv = !eill && (op[7:4] == 4'h3 || op[7:4] == 4'h9);
    @(negedge clk);
    opcode = op; dstVal = d; srcVal = s; imm = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (isDiv) begin
      cnt = 0;
      while (busy) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == 64, $sformatf("R6 %s busy cycles: actual %0d expected 64", tag, cnt));
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired (R6 completion): actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !writeEn && !illegal,
          $sformatf("R11 reset state: actual busy=%0d done=%0d we=%0d ill=%0d expected 0000",
                    busy, done, writeEn, illegal));
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R3 / R2 add and immediate extension
    send(8'h07, 64'd5, 64'd0, 32'hFFFF_FFFF, 64'd4, 0, "R3 wide add sign-extended imm");
    send(8'h04, 64'hFFFF_FFFF_0000_0005, 64'd0, 32'hFFFF_FFFF, 64'd4, 0, "R3 R2 narrow add zero-extended imm");
    send(8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'h0, 64'd1, 0, "R2 wide add wrap");
    send(8'h1C, 64'h0000_0001_0000_0000, 64'd1, 32'h0, 64'h0000_0000_FFFF_FFFF, 0, "R2 narrow sub wrap");
    send(8'h2F, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 32'h0,
         64'h0000_0002_0000_0001, 0, "R1 R2 wide mul wrap");
    send(8'h4F, 64'hF0F0_0000_0000_000F, 64'h0000_0000_0000_00F0, 32'h0,
         64'hF0F0_0000_0000_00FF, 0, "R1 wide or");
    send(8'h5C, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_0F0F_0F0F, 32'h0,
         64'h0000_0000_0204_0608, 0, "R1 R2 narrow and");
    send(8'hAF, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0,
         64'h5555_5555_5555_5555, 0, "R1 wide xor");

    // R4 shifts
    send(8'h6F, 64'd1, 64'h41, 32'h0, 64'd2, 0, "R4 wide shl count masked to 6 bits");
    send(8'h6C, 64'h0000_0000_8000_0001, 64'h21, 32'h0, 64'd2, 0, "R4 narrow shl count masked to 5 bits");
    send(8'h7F, 64'h8000_0000_0000_0000, 64'd63, 32'h0, 64'd1, 0, "R4 wide logical shr");
    send(8'hCF, 64'h8000_0000_0000_0000, 64'd4, 32'h0, 64'hF800_0000_0000_0000, 0, "R4 wide sar");
    send(8'hC4, 64'h1234_5678_8000_0000, 64'd0, 32'd4, 64'h0000_0000_F800_0000, 0, "R4 narrow sar imm");

    // R5 negate and move
    send(8'h87, 64'd1, 64'd77, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5 wide negate");
    send(8'h84, 64'd1, 64'd77, 32'h0, 64'h0000_0000_FFFF_FFFF, 0, "R5 R2 narrow negate");
    send(8'hB7, 64'h1234, 64'd0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0, "R5 R3 wide move imm");
    send(8'hB4, 64'h1234, 64'd0, 32'h8000_0000, 64'h0000_0000_8000_0000, 0, "R5 R3 narrow move imm");
    send(8'hBF, 64'h1234, 64'hDEAD_BEEF_0000_0001, 32'h0, 64'hDEAD_BEEF_0000_0001, 0, "R5 wide move reg");

    // R6 / R7 divide and modulo
    send(8'h3F, 64'd100, 64'd7, 32'h0, 64'd14, 0, "R6 wide div");
    send(8'h9F, 64'd100, 64'd7, 32'h0, 64'd2, 0, "R6 wide mod");
    send(8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 64'd1, 0, "R3 R6 wide div sign-extended imm");
    send(8'h34, 64'hAAAA_0000_0000_0064, 64'd0, 32'd10, 64'd10, 0, "R6 R2 narrow div imm");
    send(8'h3F, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0001_0003, 32'h0,
         64'hFEDC_BA98_7654_3210 / 64'h0000_0000_0001_0003, 0, "R6 wide div large");
    send(8'h3F, 64'd55, 64'd0, 32'h0, 64'd0, 0, "R7 wide div by zero");
    send(8'h9F, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'h0, 64'h1234_5678_9ABC_DEF0, 0, "R7 wide mod by zero");
    send(8'h9C, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 32'h0,
         64'h0000_0000_9ABC_DEF0, 0, "R7 narrow mod by zero");

    // R8 byte swap
    send(8'hD4, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16, 64'h0000_0000_0000_7788, 0, "R8 to-little 16");
    send(8'hD4, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd32, 64'h0000_0000_5566_7788, 0, "R8 to-little 32");
    send(8'hD4, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd64, 64'h1122_3344_5566_7788, 0, "R8 to-little 64");
    send(8'hDC, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16, 64'h0000_0000_0000_8877, 0, "R8 to-big 16");
    send(8'hDC, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd32, 64'h0000_0000_8877_6655, 0, "R8 to-big 32");
    send(8'hDC, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd64, 64'h8877_6655_4433_2211, 0, "R8 to-big 64");

    // R9 illegal encodings
    send(8'h05, 64'd1, 64'd1, 32'd1, 64'd0, 1, "R9 bad class");
    send(8'hE7, 64'd1, 64'd1, 32'd1, 64'd0, 1, "R9 code E");
    send(8'hDF, 64'd1, 64'd1, 32'd64, 64'd0, 1, "R9 swap in wide class");
    send(8'hD4, 64'd1, 64'd1, 32'd8, 64'd0, 1, "R9 swap width 8");
    send(8'hF4, 64'd1, 64'd1, 32'd1, 64'd0, 1, "R9 code F");

    // R10 issues during a divide and in its done cycle are ignored
    begin
      exp_t e;
      int cnt;
      e.res = 64'd33; e.ill = 0; e.tag = "R10 div with ignored issues";
      sbq.push_back(e);
      @(negedge clk);
      opcode = 8'h3F; dstVal = 64'd100; srcVal = 64'd3; start = 1'b1;
      @(negedge clk);
      opcode = 8'h07; dstVal = 64'd9; imm = 32'd1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (busy) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == 64, $sformatf("R10 busy cycles: actual %0d expected 64", cnt));
      opcode = 8'hB7; imm = 32'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(!done && !busy, $sformatf("R10 no completion from ignored issue: done=%0d busy=%0d expected 0 0",
                                      done, busy));
    end

    repeat (2) @(negedge clk);
    check(sbq.size() == 0, $sformatf("R6 scoreboard drained: actual %0d pending expected 0", sbq.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule